// File: doc/BRIEF.md
# In-DRAM compute command sequencer

This block sits on the controller side of a DRAM channel. It turns two high-level in-array operations into raw command streams, and it breaks the usual activate and precharge timing on purpose. A row-copy request senses a source row fully, precharges, and then activates the destination row before the bitlines have settled. The still-driven bitlines then overwrite the destination cells. A majority request activates a first row, precharges almost at once and activates a second row straight after. Several rows are then open together, and each bitline settles to the majority value of the cells on it. Every operation acts on all columns of a row at once, so no column command is ever issued.

Requests arrive on a valid/ready port with an opcode, a bank, two row addresses and a row-count field. Only one operation runs at a time. The command bus carries one command per cycle (no-op, activate or precharge) together with a bank and a row. Each operation ends with a closing precharge and a full legal precharge wait, and then a one-cycle done pulse. Two programmable registers set the short gaps. A guard input swaps those gaps for legal values, so the same sequence runs as ordinary safe accesses. A request that cannot work on the array gets a one-cycle error pulse and produces no commands.

Top module: `rowop_sequencer`

## Requirements
- R1: `req_ready` is high exactly when no operation is in flight. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance until the done or error pulse.
- R2: `cmd_type` uses the encoding 0 = NOP, 1 = ACT, 2 = PRE, and the value 3 never appears. NOP is driven on every cycle in which `req_ready` is high.
- R3: For a row copy (`req_op` = 0), the ACT to `req_row_a` appears on the bus in the cycle after acceptance. The PRE follows T_RAS cycles later. The ACT to `req_row_b` follows the PRE by the effective precharge-to-activate gap. All commands carry `req_bank`.
- R4: For a majority operation (`req_op` = 1), the ACT to `req_row_a` appears in the cycle after acceptance. The PRE follows after the effective activate-to-precharge gap. The ACT to `req_row_b` follows the PRE by the effective precharge-to-activate gap.
- R5: The gap registers reset to 1 and are loaded from `cfg_gap_pa` and `cfg_gap_ap` on a cycle where `cfg_wr` is high. A stored 0 acts as 1. The values are captured when a request is accepted.
- R6: While `cfg_guard` is high at acceptance, the precharge-to-activate gap is T_RP and the activate-to-precharge gap is T_RAS, whatever the registers hold.
- R7: A closing PRE comes T_RAS cycles after the second ACT. `done` is high for one cycle, T_RP cycles after the closing PRE, and `req_ready` is high again in that same cycle.
- R8: If the two rows differ in their subarray index (row bits above the low SUB_W bits), the request is rejected. `err` pulses for one cycle in the cycle after acceptance, and no command is issued.
- R9: A majority request whose `req_rows` lies outside 2 to 32 is rejected in the same way as R8. A row copy ignores `req_rows`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 1 | 0 = row copy, 1 = majority |
| req_bank | input | BANK_W | Target bank |
| req_row_a | input | ROW_W | Source row / first opened row |
| req_row_b | input | ROW_W | Destination row / second opened row |
| req_rows | input | CNT_W | Number of rows opened together (majority only) |
| cfg_wr | input | 1 | Load the gap registers |
| cfg_gap_pa | input | GAP_W | Precharge-to-activate gap in cycles |
| cfg_gap_ap | input | GAP_W | Activate-to-precharge gap in cycles (majority) |
| cfg_guard | input | 1 | Use legal timing in place of the short gaps |
| cmd_type | output | 2 | Command: 0 NOP, 1 ACT, 2 PRE |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Command row |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |

## Verification
On every cycle the assertions check several properties: the command encoding stays legal, the bus is quiet while idle, an accepted request yields either an ACT or an error next, a rejection is silent, and done is a single pulse exactly T_RP cycles after the last precharge. The exact spacing of the inner commands depends on the captured gap registers and the guard setting. The bench shows it by sweeping both gaps, both opcodes and both guard settings against arithmetic expectations. It also feeds the observed command times into a row-buffer model. That model shows that short gaps copy or take the majority of row data, while guarded timing leaves the array untouched. Range and subarray rejection are shown by the bench's boundary requests.

// File: rtl/rowop_pkg.sv
package rowop_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_PRE = 2'd2
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE1,
    ST_ACT2,
    ST_PRE2,
    ST_DONE
  } st_e;
endpackage

// File: rtl/rowop_cfg.sv
module rowop_cfg #(
  parameter int GAP_W = 4,
  parameter int T_RP  = 4,
  parameter int T_RAS = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [GAP_W-1:0] cfg_gap_pa,
  input  logic [GAP_W-1:0] cfg_gap_ap,
  input  logic             cfg_guard,
  output logic [GAP_W-1:0] eff_pa,
  output logic [GAP_W-1:0] eff_ap
);
  localparam logic [GAP_W-1:0] ONE   = GAP_W'(1);
  localparam logic [GAP_W-1:0] LEGAL_PA = GAP_W'(T_RP);
  localparam logic [GAP_W-1:0] LEGAL_AP = GAP_W'(T_RAS);

  logic [GAP_W-1:0] gap_pa_q, gap_ap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_pa_q <= ONE;
      gap_ap_q <= ONE;
    end else if (cfg_wr) begin
      gap_pa_q <= cfg_gap_pa;
      gap_ap_q <= cfg_gap_ap;
    end
  end

  always_comb begin
    if (cfg_guard) begin
      eff_pa = LEGAL_PA;
      eff_ap = LEGAL_AP;
    end else begin
      eff_pa = (gap_pa_q == '0) ? ONE : gap_pa_q;
      eff_ap = (gap_ap_q == '0) ? ONE : gap_ap_q;
    end
  end
endmodule

// File: rtl/rowop_check.sv
module rowop_check #(
  parameter int ROW_W    = 10,
  parameter int SUB_W    = 6,
  parameter int CNT_W    = 6,
  parameter int MIN_ROWS = 2,
  parameter int MAX_ROWS = 32
) (
  input  logic             op_maj,
  input  logic [ROW_W-1:0] row_a,
  input  logic [ROW_W-1:0] row_b,
  input  logic [CNT_W-1:0] rows,
  output logic             ok
);
  localparam logic [CNT_W-1:0] LO = CNT_W'(MIN_ROWS);
  localparam logic [CNT_W-1:0] HI = CNT_W'(MAX_ROWS);

  logic same_sub, count_ok;

  always_comb begin
    same_sub = (row_a[ROW_W-1:SUB_W] == row_b[ROW_W-1:SUB_W]);
    count_ok = (rows >= LO) && (rows <= HI);
    ok       = same_sub && (!op_maj || count_ok);
  end
endmodule

// File: rtl/rowop_timer.sv
module rowop_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/rowop_sequencer.sv
module rowop_sequencer #(
  parameter int BANK_W   = 3,
  parameter int ROW_W    = 10,
  parameter int SUB_W    = 6,
  parameter int CNT_W    = 6,
  parameter int GAP_W    = 4,
  parameter int T_RAS    = 6,
  parameter int T_RP     = 4,
  parameter int MIN_ROWS = 2,
  parameter int MAX_ROWS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row_a,
  input  logic [ROW_W-1:0]  req_row_b,
  input  logic [CNT_W-1:0]  req_rows,
  input  logic              cfg_wr,
  input  logic [GAP_W-1:0]  cfg_gap_pa,
  input  logic [GAP_W-1:0]  cfg_gap_ap,
  input  logic              cfg_guard,
  output logic [1:0]        cmd_type,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic              done,
  output logic              err
);
  import rowop_pkg::*;

  localparam logic [GAP_W-1:0] RAS_M1 = GAP_W'(T_RAS - 1);
  localparam logic [GAP_W-1:0] RP_M1  = GAP_W'(T_RP - 1);

  st_e              st;
  logic [GAP_W-1:0] eff_pa, eff_ap, pa_q;
  logic [ROW_W-1:0] row_b_q;
  logic             req_ok, accept, t_zero, t_load;
  logic [GAP_W-1:0] t_val;

  rowop_cfg #(.GAP_W(GAP_W), .T_RP(T_RP), .T_RAS(T_RAS)) u_cfg (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_gap_pa(cfg_gap_pa),
    .cfg_gap_ap(cfg_gap_ap), .cfg_guard(cfg_guard),
    .eff_pa(eff_pa), .eff_ap(eff_ap)
  );

  rowop_check #(.ROW_W(ROW_W), .SUB_W(SUB_W), .CNT_W(CNT_W),
                .MIN_ROWS(MIN_ROWS), .MAX_ROWS(MAX_ROWS)) u_chk (
    .op_maj(req_op), .row_a(req_row_a), .row_b(req_row_b),
    .rows(req_rows), .ok(req_ok)
  );

  rowop_timer #(.W(GAP_W)) u_tmr (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // Gap to wait after the command issued in the current state.
  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    unique case (st)
      ST_IDLE: if (accept && req_ok) begin
        t_load = 1'b1;
        t_val  = req_op ? (eff_ap - 1'b1) : RAS_M1;
      end
      ST_PRE1: if (t_zero) begin
        t_load = 1'b1;
        t_val  = pa_q - 1'b1;
      end
      ST_ACT2: if (t_zero) begin
        t_load = 1'b1;
        t_val  = RAS_M1;
      end
      ST_PRE2: if (t_zero) begin
        t_load = 1'b1;
        t_val  = RP_M1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cmd_type <= CMD_NOP;
      cmd_bank <= '0;
      cmd_row  <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      pa_q     <= '0;
      row_b_q  <= '0;
    end else begin
      cmd_type <= CMD_NOP;
      done     <= 1'b0;
      err      <= 1'b0;
      unique case (st)
        ST_IDLE: if (accept) begin
          if (req_ok) begin
            cmd_type <= CMD_ACT;
            cmd_bank <= req_bank;
            cmd_row  <= req_row_a;
            row_b_q  <= req_row_b;
            pa_q     <= eff_pa;
            st       <= ST_PRE1;
          end else begin
            err <= 1'b1;
          end
        end
        ST_PRE1: if (t_zero) begin
          cmd_type <= CMD_PRE;
          st       <= ST_ACT2;
        end
        ST_ACT2: if (t_zero) begin
          cmd_type <= CMD_ACT;
          cmd_row  <= row_b_q;
          st       <= ST_PRE2;
        end
        ST_PRE2: if (t_zero) begin
          cmd_type <= CMD_PRE;
          st       <= ST_DONE;
        end
        ST_DONE: if (t_zero) begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rowop_sva.sv
module rowop_sva #(
  parameter int T_RP = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] cmd_type,
  input logic       done,
  input logic       err
);
  logic [7:0] since_pre;

  always_ff @(posedge clk) begin
    if (rst)                     since_pre <= 8'hFF;
    else if (cmd_type == 2'd2)   since_pre <= 8'd1;
    else if (since_pre != 8'hFF) since_pre <= since_pre + 8'd1;
  end

  p_cmd_legal_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_type != 2'd3);

  p_idle_nop_r2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> cmd_type == 2'd0);

  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (cmd_type == 2'd1 || err));

  p_err_silent_r8: assert property (@(posedge clk) disable iff (rst)
    err |-> (cmd_type == 2'd0 && !done && req_ready));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_gap_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (since_pre == 8'(T_RP) && req_ready));
endmodule

bind rowop_sequencer rowop_sva #(.T_RP(T_RP)) u_sva (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .cmd_type(cmd_type), .done(done), .err(err)
);

// File: tb/sim_rowop_sequencer.sv
module sim_rowop_sequencer;
  localparam int BANK_W = 3, ROW_W = 10, SUB_W = 6, CNT_W = 6, GAP_W = 4;
  localparam int T_RAS = 6, T_RP = 4;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_op = 0, cfg_wr = 0, cfg_guard = 0;
  logic [BANK_W-1:0] req_bank = 0;
  logic [ROW_W-1:0]  req_row_a = 0, req_row_b = 0;
  logic [CNT_W-1:0]  req_rows = 0;
  logic [GAP_W-1:0]  cfg_gap_pa = 0, cfg_gap_ap = 0;
  logic req_ready, done, err;
  logic [1:0] cmd_type;
  logic [BANK_W-1:0] cmd_bank;
  logic [ROW_W-1:0]  cmd_row;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] mem [128];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rowop_sequencer u0 (.*);

  always @(posedge clk) if (cyc == 60000) begin
    errors++;
    $display("FAIL watchdog: run hung, actual cyc=%0d expected < 60000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] maj3(input logic [7:0] x, y, z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  task automatic set_cfg(input int pa, input int ap);
    @(negedge clk);
    cfg_wr = 1; cfg_gap_pa = GAP_W'(pa); cfg_gap_ap = GAP_W'(ap);
    @(negedge clk);
    cfg_wr = 0;
  endtask

  // Run one request; exp_pa/exp_ap are the gaps the requirements predict.
  task automatic run_op(input bit op, input int a, input int b, input int rows,
                        input int bank, input bit guard, input int exp_pa,
                        input int exp_ap, input bit exp_ok, input string tag);
    int t_acc, n, t_done, t_err;
    int et[8]; int ety[8]; int er[8]; int eb[8];
    int ea_exp, pa_obs, ap_obs;
    logic [7:0] va, vb, vc, m, want_b;
    n = 0; t_done = -1; t_err = -1;
    cfg_guard = guard;
    @(negedge clk);
    req_valid = 1; req_op = op; req_row_a = ROW_W'(a); req_row_b = ROW_W'(b);
    req_rows = CNT_W'(rows); req_bank = BANK_W'(bank);
    t_acc = cyc + 1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (i == 0) begin
        req_valid = 0;
        if (exp_ok) chk(req_ready == 0, {tag, " R1 busy ready"}, req_ready, 0);
      end
      if (cmd_type != 0 && n < 8) begin
        et[n] = cyc; ety[n] = cmd_type; er[n] = cmd_row; eb[n] = cmd_bank; n++;
      end
      if (done) t_done = cyc;
      if (err) t_err = cyc;
      if (done || err) break;
    end
    if (!exp_ok) begin
      chk(t_err == t_acc && n == 0, {tag, " R8/R9 reject"}, t_err, t_acc);
      chk(req_ready == 1, {tag, " R1 ready after reject"}, req_ready, 1);
      return;
    end
    chk(n == 4, {tag, " event count"}, n, 4);
    if (n != 4) return;
    ea_exp = op ? exp_ap : T_RAS;
    chk(ety[0] == 1 && et[0] == t_acc && er[0] == a && eb[0] == bank,
        {tag, op ? " R4 first ACT" : " R3 first ACT"}, et[0], t_acc);
    chk(ety[1] == 2 && et[1] - et[0] == ea_exp,
        {tag, op ? " R4 ACT-PRE gap" : " R3 ACT-PRE gap"}, et[1] - et[0], ea_exp);
    chk(ety[2] == 1 && et[2] - et[1] == exp_pa && er[2] == b && eb[2] == bank,
        {tag, " R5/R6 PRE-ACT gap"}, et[2] - et[1], exp_pa);
    chk(ety[3] == 2 && et[3] - et[2] == T_RAS, {tag, " R7 closing PRE"},
        et[3] - et[2], T_RAS);
    chk(t_done == et[3] + T_RP && req_ready, {tag, " R7 done"}, t_done, et[3] + T_RP);
    // Row-buffer model driven by the observed command times.
    va = mem[a]; vb = mem[b]; vc = mem[b+1];
    ap_obs = et[1] - et[0]; pa_obs = et[2] - et[1];
    if (pa_obs < T_RP) begin
      if (ap_obs >= T_RAS) mem[b] = mem[a];
      else begin
        m = maj3(mem[a], mem[b], mem[b+1]);
        mem[a] = m; mem[b] = m; mem[b+1] = m;
      end
    end
    if (guard) want_b = vb;
    else if (op) want_b = maj3(va, vb, vc);
    else want_b = va;
    chk(mem[b] == want_b, {tag, op ? " R4 model majority" : " R3 model copy"},
        mem[b], want_b);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready == 1 && cmd_type == 0 && !done && !err, "R2 reset state",
        {req_ready, cmd_type, done, err}, 5'b10000);
    // Reset-default gaps of 1.
    run_op(1, 2, 20, 3, 1, 0, 1, 1, 1, "default");
    run_op(0, 4, 22, 0, 2, 0, 1, 1, 1, "default copy R9 ignores count");
    // Sweep gaps, opcodes and guard.
    for (int g = 0; g < 2; g++)
      for (int op = 0; op < 2; op++)
        for (int ap = 1; ap <= 3; ap++)
          for (int pa = 1; pa <= 3; pa++) begin
            set_cfg(pa, ap);
            run_op(op[0], (ap * 7 + pa) % 20, 40 + pa + 3 * op, 3, ap,
                   g[0], g ? T_RP : pa, g ? T_RAS : ap, 1, "sweep");
          end
    // A stored zero acts as one.
    set_cfg(0, 0);
    run_op(1, 1, 30, 5, 0, 0, 1, 1, 1, "R5 zero gap");
    // Rejections and row-count boundaries.
    run_op(0, 5, 69, 2, 0, 0, 1, 1, 0, "R8 cross subarray copy");
    run_op(1, 70, 5, 3, 0, 0, 1, 1, 0, "R8 cross subarray maj");
    run_op(1, 6, 9, 0, 0, 0, 1, 1, 0, "R9 rows 0");
    run_op(1, 6, 9, 1, 0, 0, 1, 1, 0, "R9 rows 1");
    run_op(1, 6, 9, 33, 0, 0, 1, 1, 0, "R9 rows 33");
    run_op(1, 6, 9, 63, 0, 0, 1, 1, 0, "R9 rows 63");
    run_op(1, 6, 9, 2, 0, 0, 1, 1, 1, "R9 rows 2");
    run_op(1, 6, 9, 32, 0, 0, 1, 1, 1, "R9 rows 32");
    repeat (3) @(negedge clk);
    chk(cmd_type == 0 && req_ready, "R2 idle NOP", cmd_type, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule